// File: doc/BRIEF.md
# Reset-Gated Audio Configuration Register

This block holds one 8-bit audio configuration word behind a byte-wide control port. A serial shifter outside the block delivers whole bytes with a one-cycle valid strobe and accepts reply bytes the same way. The first byte of each transaction is a command. One command code stores the byte that follows it. A second command code sends the stored word back. Any other command byte is dropped.

The stored word has three fields. A sample-rate code selects one of five rate modes. A format code selects the serial input format. A clock-hold bit keeps the audio clock domain in reset while it is 1. A store is honoured only while the active-low system reset input is held low, so software can change the configuration only while the chip is parked.

Rate and format settings do not reach the outputs when they are written. They are committed only when the clock-hold bit falls from 1 to 0. At that point the block gives a one-cycle commit pulse. From the committed rate code it decodes a mode index, a count of processing steps per sample, and enables for the converter paths. A rate code with no mode raises an error flag and leaves the decoded outputs unchanged.

Top module: `audio_cfg_reg`

## Requirements
- R1: After the power-on reset `por_n` is released, the following values hold: the stored word is 0x00, `clk_rst` is 0 and `apply` is 0, `rate_mode` is 0, `step_count` is 768, `fmt_code` is 0, `adc_en` is 1, `dac_en` is 1 and `rate_err` is 0.
- R2: The command byte 0x60 stores the next received byte, provided `sys_rst_n` is low in the cycle that byte arrives. The byte's bits 7:1 are stored and bit 0 is stored as 0. Field positions are: rate code in bits 7:5, format code in bits 4:2, clock-hold in bit 1.
- R3: A data byte that follows 0x60 while `sys_rst_n` is high is consumed and has no effect on the stored word.
- R4: The command byte 0x70 makes `tx_valid` high for exactly one cycle, in the cycle after the command byte. In that cycle `tx_byte` carries the stored word with bit 0 as 0. While `tx_valid` is low, `tx_byte` is 0.
- R5: Any other byte received as a command is ignored, and the next byte is again treated as a command.
- R6: `clk_rst` equals stored bit 1 from the clock edge that stores it.
- R7: `apply` is high for exactly one cycle. It rises one clock after the stored clock-hold bit changes from 1 to 0.
- R8: `rate_mode`, `step_count`, `fmt_code`, `adc_en`, `dac_en` and `rate_err` change only on the edge that raises `apply`. A newly stored rate or format does not reach them until then.
- R9: The committed rate code decodes as follows: code 0 gives mode 0 with 768 steps, code 1 gives mode 1 with 384, code 2 gives mode 2 with 192, code 3 gives mode 3 with 1152, and code 7 gives mode 4 with 4608. Each step count is `CORE_HZ` divided by the rate, for rates of 48, 96, 192, 32 and 8 kHz.
- R10: `adc_en` is 0 in modes 1 and 2 and 1 in the other modes. `dac_en` is 1 in every valid mode.
- R11: When the committed rate code is 4, 5 or 6, `rate_err` becomes 1 and `rate_mode`, `step_count`, `adc_en` and `dac_en` keep their previous values. The next commit of a valid code clears `rate_err`.
- R12: At each commit, `fmt_code` takes the stored format field whatever the rate code is.

### Command sequencer states and transitions
- CP_IDLE: waits for a command byte. It goes to CP_WDATA on byte 0x60 and to CP_RESP on byte 0x70. On any other byte it stays in CP_IDLE.
- CP_WDATA: the next received byte is the data byte, which is stored if the write gate is open. The sequencer then returns to CP_IDLE.
- CP_RESP: drives the reply for one cycle and then returns to CP_IDLE. A byte that arrives in this cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_n | input | 1 | System reset, active low; opens the write gate while low |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte from the shifter |
| tx_valid | output | 1 | One-cycle strobe: a reply byte is present |
| tx_byte | output | 8 | Reply byte to the shifter |
| clk_rst | output | 1 | Clock-domain reset, equal to the stored clock-hold bit |
| apply | output | 1 | One-cycle commit pulse |
| rate_mode | output | 3 | Committed rate mode index (0 to 4) |
| step_count | output | 13 | Committed processing steps per sample |
| fmt_code | output | 3 | Committed input format code |
| adc_en | output | 1 | Converter input path available in this mode |
| dac_en | output | 1 | Converter output path available in this mode |
| rate_err | output | 1 | The last committed rate code was invalid |

## Verification
The bench builds the block with its default parameters: command codes 0x60 and 0x70, a 13-bit step count, and `CORE_HZ` of 36 864 000. With these values all five rate modes and all three invalid rate codes can be committed, so the bench covers the full decode table and the hold-on-error path. A behavioural model in the bench is compared with the outputs on every clock. This comparison covers the sequencer's handling of unknown commands, writes that arrive while the write gate is closed, and commit pulses that are deliberately delayed by holding the clock-hold bit at 1.

// File: rtl/acfg_pkg.sv
package acfg_pkg;

    // Command sequencer states
    typedef enum logic [1:0] {
        CP_IDLE  = 2'd0,
        CP_WDATA = 2'd1,
        CP_RESP  = 2'd2
    } cp_state_e;

    // Field positions inside the stored word (decoded by the commit stage)
    localparam int RATE_HI = 7;
    localparam int RATE_LO = 5;
    localparam int FMT_HI  = 4;
    localparam int FMT_LO  = 2;
    localparam int CKR_BIT = 1;

    typedef struct packed {
        logic       ok;
        logic [2:0] mode;
        logic       adc;
        logic       dac;
    } rate_info_t;

    // Rate code to mode decode; unused codes report ok = 0
    function automatic rate_info_t rate_lookup(input logic [2:0] code);
        rate_info_t r;
        r = '{ok: 1'b0, mode: 3'd0, adc: 1'b0, dac: 1'b0};
        unique case (code)
            3'd0: r = '{ok: 1'b1, mode: 3'd0, adc: 1'b1, dac: 1'b1};
            3'd1: r = '{ok: 1'b1, mode: 3'd1, adc: 1'b0, dac: 1'b1};
            3'd2: r = '{ok: 1'b1, mode: 3'd2, adc: 1'b0, dac: 1'b1};
            3'd3: r = '{ok: 1'b1, mode: 3'd3, adc: 1'b1, dac: 1'b1};
            3'd7: r = '{ok: 1'b1, mode: 3'd4, adc: 1'b1, dac: 1'b1};
            default: r = '{ok: 1'b0, mode: 3'd0, adc: 1'b0, dac: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/acfg_cmd_fsm.sv
module acfg_cmd_fsm
    import acfg_pkg::*;
#(
    parameter int          W      = 8,
    parameter logic [W-1:0] WR_CMD = 8'h60,
    parameter logic [W-1:0] RD_CMD = 8'h70
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_byte,
    input  logic [W-1:0] rd_data,
    output logic         wr_stb,
    output logic [W-1:0] wr_data,
    output logic         tx_valid,
    output logic [W-1:0] tx_byte
);

    cp_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CP_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CP_IDLE: begin
                if (rx_valid) begin
                    if (rx_byte == WR_CMD)      state_d = CP_WDATA;
                    else if (rx_byte == RD_CMD) state_d = CP_RESP;
                    else                        state_d = CP_IDLE;
                end
            end
            CP_WDATA: if (rx_valid) state_d = CP_IDLE;
            CP_RESP:  state_d = CP_IDLE;
            default:  state_d = CP_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        wr_stb   = 1'b0;
        wr_data  = rx_byte;
        tx_valid = 1'b0;
        tx_byte  = '0;
        unique case (state_q)
            CP_IDLE:  ;
            CP_WDATA: wr_stb = rx_valid;
            CP_RESP: begin
                tx_valid = 1'b1;
                tx_byte  = rd_data;
            end
            default: ;
        endcase
    end

    // R4: a reply lasts one cycle
    a_r4_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    // R5: an unknown command leaves the sequencer idle
    a_r5_unknown_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CP_IDLE && rx_valid && rx_byte != WR_CMD && rx_byte != RD_CMD)
        |=> (state_q == CP_IDLE));

endmodule

// File: rtl/acfg_store.sv
module acfg_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sys_rst_n,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cfg_o
);

    localparam logic [W-1:0] KEEP_MASK = {{(W-1){1'b1}}, 1'b0};

    logic [W-1:0] cfg_q;
    logic         gate_open;

    assign gate_open = ~sys_rst_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cfg_q <= '0;
        else if (wr_stb && gate_open)   cfg_q <= wr_data & KEEP_MASK;
    end

    assign cfg_o = cfg_q;

    // R3: a data byte with the gate closed leaves the word unchanged
    a_r3_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && sys_rst_n) |=> $stable(cfg_q));

endmodule

// File: rtl/acfg_commit.sv
module acfg_commit
    import acfg_pkg::*;
#(
    parameter int          W       = 8,
    parameter int          STEP_W  = 13,
    parameter int unsigned CORE_HZ = 36_864_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      cfg_i,
    output logic              apply_o,
    output logic [2:0]        mode_o,
    output logic [STEP_W-1:0] step_o,
    output logic [2:0]        fmt_o,
    output logic              adc_o,
    output logic              dac_o,
    output logic              err_o
);

    localparam logic [STEP_W-1:0] STEP_48K  = STEP_W'(CORE_HZ / 48_000);
    localparam logic [STEP_W-1:0] STEP_96K  = STEP_W'(CORE_HZ / 96_000);
    localparam logic [STEP_W-1:0] STEP_192K = STEP_W'(CORE_HZ / 192_000);
    localparam logic [STEP_W-1:0] STEP_32K  = STEP_W'(CORE_HZ / 32_000);
    localparam logic [STEP_W-1:0] STEP_8K   = STEP_W'(CORE_HZ / 8_000);

    logic              ckr_prev_q;
    logic              fall;
    rate_info_t        info;
    logic [STEP_W-1:0] step_sel;

    assign fall = ckr_prev_q & ~cfg_i[CKR_BIT];
    assign info = rate_lookup(cfg_i[RATE_HI:RATE_LO]);

    always_comb begin
        unique case (info.mode)
            3'd1:    step_sel = STEP_96K;
            3'd2:    step_sel = STEP_192K;
            3'd3:    step_sel = STEP_32K;
            3'd4:    step_sel = STEP_8K;
            default: step_sel = STEP_48K;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ckr_prev_q <= 1'b0;
            apply_o    <= 1'b0;
            mode_o     <= 3'd0;
            step_o     <= STEP_48K;
            fmt_o      <= 3'd0;
            adc_o      <= 1'b1;
            dac_o      <= 1'b1;
            err_o      <= 1'b0;
        end else begin
            ckr_prev_q <= cfg_i[CKR_BIT];
            apply_o    <= fall;
            if (fall) begin
                fmt_o <= cfg_i[FMT_HI:FMT_LO];
                if (info.ok) begin
                    mode_o <= info.mode;
                    step_o <= step_sel;
                    adc_o  <= info.adc;
                    dac_o  <= info.dac;
                    err_o  <= 1'b0;
                end else begin
                    err_o  <= 1'b1;
                end
            end
        end
    end

    // R7: commit pulse is one cycle wide
    a_r7_apply_single: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |=> !apply_o);

    // R8: decoded outputs move only together with the commit pulse
    a_r8_step_only_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(step_o) |-> apply_o);

    a_r8_fmt_only_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fmt_o) |-> apply_o);

    // R11: an invalid commit keeps the decoded rate outputs
    a_r11_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_o && err_o) |-> ($stable(step_o) && $stable(mode_o)));

    // R10: the converter input path is off in the two fast modes
    a_r10_adc_off_fast: assert property (@(posedge clk) disable iff (!rst_n)
        adc_o |-> (mode_o != 3'd1 && mode_o != 3'd2));

endmodule

// File: rtl/audio_cfg_reg.sv
module audio_cfg_reg
    import acfg_pkg::*;
#(
    parameter int          W       = 8,
    parameter logic [W-1:0] WR_CMD  = 8'h60,
    parameter logic [W-1:0] RD_CMD  = 8'h70,
    parameter int          STEP_W  = 13,
    parameter int unsigned CORE_HZ = 36_864_000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              rx_valid,
    input  logic [W-1:0]      rx_byte,
    output logic              tx_valid,
    output logic [W-1:0]      tx_byte,
    output logic              clk_rst,
    output logic              apply,
    output logic [2:0]        rate_mode,
    output logic [STEP_W-1:0] step_count,
    output logic [2:0]        fmt_code,
    output logic              adc_en,
    output logic              dac_en,
    output logic              rate_err
);

    logic         wr_stb;
    logic [W-1:0] wr_data;
    logic [W-1:0] cfg;

    acfg_cmd_fsm #(.W(W), .WR_CMD(WR_CMD), .RD_CMD(RD_CMD)) u_fsm (
        .clk      (clk),
        .rst_n    (por_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rd_data  (cfg),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte)
    );

    acfg_store #(.W(W)) u_store (
        .clk       (clk),
        .rst_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .cfg_o     (cfg)
    );

    acfg_commit #(.W(W), .STEP_W(STEP_W), .CORE_HZ(CORE_HZ)) u_commit (
        .clk     (clk),
        .rst_n   (por_n),
        .cfg_i   (cfg),
        .apply_o (apply),
        .mode_o  (rate_mode),
        .step_o  (step_count),
        .fmt_o   (fmt_code),
        .adc_o   (adc_en),
        .dac_o   (dac_en),
        .err_o   (rate_err)
    );

    assign clk_rst = cfg[CKR_BIT];

    // R6: clock-domain reset mirrors the stored hold bit
    a_r6_clk_rst_follows: assert property (@(posedge clk) disable iff (!por_n)
        (wr_stb && !sys_rst_n) |=> (clk_rst == $past(wr_data[CKR_BIT])));

endmodule

// File: tb/audio_cfg_reg_tb.sv
module audio_cfg_reg_tb;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        clk_rst;
    logic        apply;
    logic [2:0]  rate_mode;
    logic [12:0] step_count;
    logic [2:0]  fmt_code;
    logic        adc_en;
    logic        dac_en;
    logic        rate_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    audio_cfg_reg u_dut (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst_n  (sys_rst_n),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte),
        .clk_rst    (clk_rst),
        .apply      (apply),
        .rate_mode  (rate_mode),
        .step_count (step_count),
        .fmt_code   (fmt_code),
        .adc_en     (adc_en),
        .dac_en     (dac_en),
        .rate_err   (rate_err)
    );

    // Behavioural reference model
    int m_state = 0;           // 0 idle, 1 awaiting data, 2 replying
    int m_word  = 0;
    int m_prev  = 0;
    int m_apply = 0;
    int m_mode  = 0;
    int m_step  = 768;
    int m_fmt   = 0;
    int m_adc   = 1;
    int m_dac   = 1;
    int m_err   = 0;

    function automatic int rate_hz(input int code);
        case (code)
            0: return 48000;
            1: return 96000;
            2: return 192000;
            3: return 32000;
            7: return 8000;
            default: return 0;
        endcase
    endfunction

    function automatic int rate_idx(input int code);
        case (code)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 3;
            7: return 4;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!por_n) begin
            m_state = 0; m_word = 0; m_prev = 0; m_apply = 0;
            m_mode = 0; m_step = 768; m_fmt = 0; m_adc = 1; m_dac = 1; m_err = 0;
        end else begin
            int hold_bit;
            int code;
            hold_bit = (m_word >> 1) & 1;
            m_apply = (m_prev == 1 && hold_bit == 0) ? 1 : 0;
            if (m_apply == 1) begin
                code  = (m_word >> 5) & 7;
                m_fmt = (m_word >> 2) & 7;
                if (rate_idx(code) >= 0) begin
                    m_mode = rate_idx(code);
                    m_step = 36864000 / rate_hz(code);
                    m_adc  = (m_mode == 1 || m_mode == 2) ? 0 : 1;
                    m_dac  = 1;
                    m_err  = 0;
                end else begin
                    m_err = 1;
                end
            end
            m_prev = hold_bit;
            case (m_state)
                0: if (rx_valid) begin
                       if (rx_byte == 8'h60)      m_state = 1;
                       else if (rx_byte == 8'h70) m_state = 2;
                   end
                1: if (rx_valid) begin
                       if (!sys_rst_n) m_word = int'(rx_byte) & 8'hFE;
                       m_state = 0;
                   end
                default: m_state = 0;
            endcase
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (por_n && !done) begin
            check("R4 tx_valid", int'(tx_valid), (m_state == 2) ? 1 : 0);
            check("R4 tx_byte", int'(tx_byte), (m_state == 2) ? m_word : 0);
            check("R6 clk_rst", int'(clk_rst), (m_word >> 1) & 1);
            check("R7 apply", int'(apply), m_apply);
            check("R9 rate_mode", int'(rate_mode), m_mode);
            check("R9 step_count", int'(step_count), m_step);
            check("R12 fmt_code", int'(fmt_code), m_fmt);
            check("R10 adc_en", int'(adc_en), m_adc);
            check("R10 dac_en", int'(dac_en), m_dac);
            check("R11 rate_err", int'(rate_err), m_err);
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'h00;
    endtask

    task automatic write_word(input logic [7:0] v);
        send(8'h60);
        send(v);
    endtask

    task automatic read_word(input string req, input int exp);
        send(8'h70);
        check({req, " reply strobe"}, int'(tx_valid), 1);
        check({req, " reply data"}, int'(tx_byte), exp);
        @(negedge clk);
        check("R4 reply one cycle", int'(tx_valid), 0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 step", int'(step_count), 768);
        check("R1 mode", int'(rate_mode), 0);
        check("R1 adc", int'(adc_en), 1);
        check("R1 dac", int'(dac_en), 1);
        check("R1 err", int'(rate_err), 0);
        check("R1 clk_rst", int'(clk_rst), 0);
        read_word("R1", 0);

        // R2 store with gate open, hold bit set; R8 no commit yet
        write_word(8'h2F);
        check("R6 hold bit", int'(clk_rst), 1);
        read_word("R2", 8'h2E);
        check("R8 step unchanged", int'(step_count), 768);
        check("R8 fmt unchanged", int'(fmt_code), 0);

        // R7 release hold -> commit
        send(8'h60);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h2C;
        @(negedge clk);
        rx_valid = 1'b0; rx_byte = 8'h00;
        check("R7 no pulse yet", int'(apply), 0);
        @(negedge clk);
        check("R7 pulse", int'(apply), 1);
        check("R9 step 96k", int'(step_count), 384);
        check("R10 adc off", int'(adc_en), 0);
        check("R12 fmt", int'(fmt_code), 3);
        @(negedge clk);
        check("R7 pulse ends", int'(apply), 0);

        // R3 write gate closed
        sys_rst_n = 1'b1;
        write_word(8'hE2);
        repeat (2) @(negedge clk);
        check("R3 hold bit untouched", int'(clk_rst), 0);
        read_word("R3", 8'h2C);
        sys_rst_n = 1'b0;

        // R5 unknown command, then a real read
        send(8'h55);
        send(8'h2F);
        read_word("R5", 8'h2C);

        // R9 / R11 sweep of every rate code
        for (int c = 0; c < 8; c++) begin
            int prev_step;
            prev_step = int'(step_count);
            write_word(8'((c << 5) | 8'h06));
            write_word(8'((c << 5) | 8'h04));
            repeat (2) @(negedge clk);
            if (rate_idx(c) >= 0) begin
                check("R9 sweep step", int'(step_count), 36864000 / rate_hz(c));
                check("R11 err cleared", int'(rate_err), 0);
            end else begin
                check("R11 err set", int'(rate_err), 1);
                check("R11 step held", int'(step_count), prev_step);
            end
            check("R12 fmt sweep", int'(fmt_code), 1);
        end

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule